// File: doc/BRIEF.md
# Shared-Memory Queue Pointer Tracker

This block keeps the bookkeeping for the transmit and receive byte queues of a serial target peripheral whose queue storage lives in system memory. It stores no payload. It holds the buffer base addresses, the size codes, the pointers and the byte counts, and on every byte the serial engine moves it presents the memory address of that byte. Software programs and inspects the block through byte-wide registers. The serial engine pulses a pop strobe for each transmitted byte and a push strobe for each received byte, plus an end-of-transfer strobe for each direction.

Two addressing modes exist. In ring mode the two buffers are small (16 to 128 bytes), share one upper base register and wrap modulo their size. Software consumes received bytes by writing back the old read pointer plus the number of bytes it took. In linear mode both directions switch together to their own 16-bit base register pairs, and end-of-transfer strobes raise done flags. An optional auto-clear then zeroes the transmit count. Transmit underrun and receive overrun are recorded as sticky flags.

Top module: `qpt_tracker`

Register offsets (reg_addr): 0x00 transmit ring base low, 0x01 receive ring base low, 0x02 shared ring base high, 0x03 size codes, 0x04/0x05 transmit length low/high, 0x06/0x07 transmit count low/high (read only), 0x08/0x09 receive count low/high (read only), 0x0A/0x0B receive read pointer low/high, 0x0C control, 0x0D status, 0x10/0x11 linear transmit base low/high, 0x12/0x13 linear receive base low/high. All registers reset to zero.

## Requirements
- R1: A base is formed as {high byte, low byte, 3'b000}. Low registers hold address bits 10:3 and high registers bits 18:11. In ring mode tx_addr uses 0x02 with 0x00 and rx_addr uses 0x02 with 0x01. Each address is the base plus the pointer offset, truncated to 19 bits.
- R2: The size register holds the transmit code in bits 3:0 and the receive code in bits 7:4. Codes 0x0, 0x5, 0x6, 0x7 and 0xC give 16, 32, 64, 128 and 4096 bytes. Any other code, or 0xC outside linear mode, is unsupported for that direction. An unsupported direction sets status bit 7 (transmit) or bit 6 (receive), and its pops or pushes change no count, pointer or flag.
- R3: The offset added to a base is the byte pointer modulo the buffer size. For transmit the pointer is the number of bytes popped, and for receive it is the write pointer.
- R4: The transmit count (0x06/0x07) equals the length written to 0x04/0x05 minus the bytes popped, and never goes below zero. A pop at count zero sets sticky status bit 2, and writing 1 to that bit clears it.
- R5: Writing a control byte with bit 0 set zeroes the transmit length and the popped count, so the transmit count reads 0 and tx_addr returns to the transmit base.
- R6: The receive count (0x08/0x09) is the write pointer minus the read pointer (0x0A/0x0B). It is taken modulo 256 in ring mode and modulo 65536 in linear mode. Software consumes bytes by rewriting the read pointer.
- R7: A push when the receive count equals the buffer size sets sticky status bit 3 (cleared by writing 1) and leaves the write pointer and count unchanged.
- R8: Linear mode is active only when control bits 5:4 are both 1. It takes its bases from 0x10/0x11 (transmit) and 0x12/0x13 (receive). Any other value of bits 5:4 selects ring mode.
- R9: In linear mode rx_xfer_end sets status bit 0 and tx_xfer_end sets status bit 1. Each bit is cleared by writing 1. In ring mode the strobes leave these bits unchanged.
- R10: With control bit 6 set, a tx_xfer_end in linear mode zeroes the transmit count. Without it, the count is kept.
- R11: After reset every register, count, pointer and status bit is zero, and both addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| tx_pop | input | 1 | Serial engine takes one transmit byte |
| tx_addr | output | 19 | Memory address of the next transmit byte |
| rx_push | input | 1 | Serial engine stores one received byte |
| rx_addr | output | 19 | Memory address for the next received byte |
| tx_xfer_end | input | 1 | Transmit transfer completed |
| rx_xfer_end | input | 1 | Receive transfer completed |

## Verification
The assertions assume that the serial engine strobes only on clock edges and that a one-cycle strobe means exactly one byte. They also assume that the count checks look only at cycles with no register write, since software may rewrite lengths or pointers at any time. The stimulus drives each strobe for one cycle between falling edges. It never writes a register in the same cycle as a push or pop. When it rewrites the read pointer, it consumes no more bytes than the model says are present, so the ring fill stays between zero and the buffer size.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
  localparam int ADDR_W = 19;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int SZ_W   = 13;
  localparam int RA_W   = 5;
  localparam int ALIGN  = 3;
  localparam int RING_W = 8;

  localparam logic [RA_W-1:0] RG_TXB_LO  = 5'h00;
  localparam logic [RA_W-1:0] RG_RXB_LO  = 5'h01;
  localparam logic [RA_W-1:0] RG_BASE_HI = 5'h02;
  localparam logic [RA_W-1:0] RG_SIZE    = 5'h03;
  localparam logic [RA_W-1:0] RG_LEN_LO  = 5'h04;
  localparam logic [RA_W-1:0] RG_LEN_HI  = 5'h05;
  localparam logic [RA_W-1:0] RG_TXC_LO  = 5'h06;
  localparam logic [RA_W-1:0] RG_TXC_HI  = 5'h07;
  localparam logic [RA_W-1:0] RG_RXC_LO  = 5'h08;
  localparam logic [RA_W-1:0] RG_RXC_HI  = 5'h09;
  localparam logic [RA_W-1:0] RG_RP_LO   = 5'h0A;
  localparam logic [RA_W-1:0] RG_RP_HI   = 5'h0B;
  localparam logic [RA_W-1:0] RG_CTRL    = 5'h0C;
  localparam logic [RA_W-1:0] RG_STAT    = 5'h0D;
  localparam logic [RA_W-1:0] RG_DTX_LO  = 5'h10;
  localparam logic [RA_W-1:0] RG_DTX_HI  = 5'h11;
  localparam logic [RA_W-1:0] RG_DRX_LO  = 5'h12;
  localparam logic [RA_W-1:0] RG_DRX_HI  = 5'h13;

  localparam logic [3:0] CODE_LINEAR = 4'hC;

  // Size code to byte count; zero marks an unsupported code.
  function automatic logic [SZ_W-1:0] size_of_code(input logic [3:0] code);
    case (code)
      4'h0:    return 13'd16;
      4'h5:    return 13'd32;
      4'h6:    return 13'd64;
      4'h7:    return 13'd128;
      4'hC:    return 13'd4096;
      default: return 13'd0;
    endcase
  endfunction

  // Bytes waiting between write and read pointer.
  function automatic logic [CNT_W-1:0] ring_fill(input logic [CNT_W-1:0] wp,
                                                 input logic [CNT_W-1:0] rp,
                                                 input logic wide);
    logic [RING_W-1:0] narrow;
    narrow = wp[RING_W-1:0] - rp[RING_W-1:0];
    if (wide) return wp - rp;
    return {{(CNT_W-RING_W){1'b0}}, narrow};
  endfunction

  // Remaining transmit bytes, clamped at zero.
  function automatic logic [CNT_W-1:0] tx_left(input logic [CNT_W-1:0] len,
                                               input logic [CNT_W-1:0] done);
    return (len > done) ? (len - done) : '0;
  endfunction

  // Memory address of the byte at pointer ptr in a buffer of the given size.
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo,
                                                  input logic [CNT_W-1:0] ptr,
                                                  input logic [SZ_W-1:0] size);
    logic [CNT_W-1:0]  mask;
    logic [ADDR_W-1:0] base;
    mask = {{(CNT_W-SZ_W){1'b0}}, size} - 1'b1;
    base = {hi, lo, {ALIGN{1'b0}}};
    return base + {{(ADDR_W-CNT_W){1'b0}}, ptr & mask};
  endfunction
endpackage

// File: rtl/qpt_regs.sv
module qpt_regs
  import qpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] txb_lo,
  output logic [BYTE_W-1:0] rxb_lo,
  output logic [BYTE_W-1:0] base_hi,
  output logic [BYTE_W-1:0] size_codes,
  output logic [BYTE_W-1:0] dtx_lo,
  output logic [BYTE_W-1:0] dtx_hi,
  output logic [BYTE_W-1:0] drx_lo,
  output logic [BYTE_W-1:0] drx_hi,
  output logic              ctl_autoclr,
  output logic [1:0]        ctl_lin_en,
  output logic              len_lo_we,
  output logic              len_hi_we,
  output logic              rp_lo_we,
  output logic              rp_hi_we,
  output logic              flush_req,
  output logic [3:0]        stat_clr
);
  logic ctl_we, stat_we;

  assign len_lo_we = reg_wr && (reg_addr == RG_LEN_LO);
  assign len_hi_we = reg_wr && (reg_addr == RG_LEN_HI);
  assign rp_lo_we  = reg_wr && (reg_addr == RG_RP_LO);
  assign rp_hi_we  = reg_wr && (reg_addr == RG_RP_HI);
  assign ctl_we    = reg_wr && (reg_addr == RG_CTRL);
  assign stat_we   = reg_wr && (reg_addr == RG_STAT);
  assign flush_req = ctl_we && reg_wdata[0];
  assign stat_clr  = stat_we ? reg_wdata[3:0] : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_lo      <= '0;
      rxb_lo      <= '0;
      base_hi     <= '0;
      size_codes  <= '0;
      dtx_lo      <= '0;
      dtx_hi      <= '0;
      drx_lo      <= '0;
      drx_hi      <= '0;
      ctl_autoclr <= 1'b0;
      ctl_lin_en  <= 2'b00;
    end else if (reg_wr) begin
      case (reg_addr)
        RG_TXB_LO:  txb_lo     <= reg_wdata;
        RG_RXB_LO:  rxb_lo     <= reg_wdata;
        RG_BASE_HI: base_hi    <= reg_wdata;
        RG_SIZE:    size_codes <= reg_wdata;
        RG_DTX_LO:  dtx_lo     <= reg_wdata;
        RG_DTX_HI:  dtx_hi     <= reg_wdata;
        RG_DRX_LO:  drx_lo     <= reg_wdata;
        RG_DRX_HI:  drx_hi     <= reg_wdata;
        RG_CTRL: begin
          ctl_autoclr <= reg_wdata[6];
          ctl_lin_en  <= reg_wdata[5:4];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qpt_txq.sv
module qpt_txq
  import qpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              len_lo_we,
  input  logic              len_hi_we,
  input  logic              flush_req,
  input  logic              tx_pop,
  input  logic              cfg_ok,
  input  logic              linear,
  input  logic              autoclr,
  input  logic              xfer_end,
  input  logic              clr_udr,
  input  logic              clr_done,
  output logic [CNT_W-1:0]  popped,
  output logic [CNT_W-1:0]  count,
  output logic              udr_flag,
  output logic              done_flag,
  output logic              pop_go,
  output logic              udr_evt,
  output logic              zero_evt
);
  logic [CNT_W-1:0] len_q;
  logic             done_evt;

  assign count    = tx_left(len_q, popped);
  assign pop_go   = tx_pop && cfg_ok && (count != '0);
  assign udr_evt  = tx_pop && cfg_ok && (count == '0);
  assign done_evt = xfer_end && linear;
  assign zero_evt = flush_req || (done_evt && autoclr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      popped <= '0;
    end else if (zero_evt) begin
      len_q  <= '0;
      popped <= '0;
    end else begin
      if (len_lo_we) len_q[BYTE_W-1:0]     <= wdata;
      if (len_hi_we) len_q[CNT_W-1:BYTE_W] <= wdata;
      if (pop_go)    popped                <= popped + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udr_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (udr_evt)       udr_flag  <= 1'b1;
      else if (clr_udr)  udr_flag  <= 1'b0;
      if (done_evt)      done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/qpt_rxq.sv
module qpt_rxq
  import qpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rp_lo_we,
  input  logic              rp_hi_we,
  input  logic              rx_push,
  input  logic              cfg_ok,
  input  logic [SZ_W-1:0]   size,
  input  logic              linear,
  input  logic              xfer_end,
  input  logic              clr_ovr,
  input  logic              clr_done,
  output logic [CNT_W-1:0]  wp,
  output logic [CNT_W-1:0]  rp,
  output logic [CNT_W-1:0]  count,
  output logic              ovr_flag,
  output logic              done_flag,
  output logic              push_go,
  output logic              ovr_evt
);
  logic full;
  logic done_evt;

  assign count    = ring_fill(wp, rp, linear);
  assign full     = count >= {{(CNT_W-SZ_W){1'b0}}, size};
  assign push_go  = rx_push && cfg_ok && !full;
  assign ovr_evt  = rx_push && cfg_ok && full;
  assign done_evt = xfer_end && linear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_go)  wp                  <= wp + 1'b1;
      if (rp_lo_we) rp[BYTE_W-1:0]     <= wdata;
      if (rp_hi_we) rp[CNT_W-1:BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (ovr_evt)       ovr_flag  <= 1'b1;
      else if (clr_ovr)  ovr_flag  <= 1'b0;
      if (done_evt)      done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/qpt_tracker.sv
module qpt_tracker
  import qpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tx_pop,
  output logic [ADDR_W-1:0] tx_addr,
  input  logic              rx_push,
  output logic [ADDR_W-1:0] rx_addr,
  input  logic              tx_xfer_end,
  input  logic              rx_xfer_end
);
  localparam int NDIR = 2;
  localparam int DTX  = 0;
  localparam int DRX  = 1;

  logic [BYTE_W-1:0] txb_lo, rxb_lo, base_hi, size_codes;
  logic [BYTE_W-1:0] dtx_lo, dtx_hi, drx_lo, drx_hi;
  logic              ctl_autoclr;
  logic [1:0]        ctl_lin_en;
  logic              len_lo_we, len_hi_we, rp_lo_we, rp_hi_we, flush_req;
  logic [3:0]        stat_clr;

  logic              linear;
  logic [NDIR-1:0][3:0]      dir_code;
  logic [NDIR-1:0][SZ_W-1:0] dir_size;
  logic [NDIR-1:0]           dir_ok;

  logic [CNT_W-1:0]  tx_popped, tx_cnt;
  logic [CNT_W-1:0]  rx_wp, rx_rp, rx_cnt;
  logic              st_udr, st_ovr, st_txdone, st_rxdone;
  logic              pop_go, udr_evt, zero_evt, push_go, ovr_evt;
  logic [SZ_W-1:0]   tx_size, rx_size;
  logic              tx_ok, rx_ok;
  logic [BYTE_W-1:0] tx_hi, tx_lo, rx_hi, rx_lo;
  logic [BYTE_W-1:0] stat_byte, ctrl_byte;

  qpt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .txb_lo(txb_lo), .rxb_lo(rxb_lo),
    .base_hi(base_hi), .size_codes(size_codes), .dtx_lo(dtx_lo),
    .dtx_hi(dtx_hi), .drx_lo(drx_lo), .drx_hi(drx_hi),
    .ctl_autoclr(ctl_autoclr), .ctl_lin_en(ctl_lin_en),
    .len_lo_we(len_lo_we), .len_hi_we(len_hi_we), .rp_lo_we(rp_lo_we),
    .rp_hi_we(rp_hi_we), .flush_req(flush_req), .stat_clr(stat_clr)
  );

  assign linear = &ctl_lin_en;
  assign dir_code[DTX] = size_codes[3:0];
  assign dir_code[DRX] = size_codes[7:4];

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign dir_size[g] = size_of_code(dir_code[g]);
    assign dir_ok[g]   = (dir_size[g] != '0) &&
                         (linear || (dir_code[g] != CODE_LINEAR));
  end

  assign tx_size = dir_size[DTX];
  assign rx_size = dir_size[DRX];
  assign tx_ok   = dir_ok[DTX];
  assign rx_ok   = dir_ok[DRX];

  qpt_txq u_txq (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata), .len_lo_we(len_lo_we),
    .len_hi_we(len_hi_we), .flush_req(flush_req), .tx_pop(tx_pop),
    .cfg_ok(tx_ok), .linear(linear), .autoclr(ctl_autoclr),
    .xfer_end(tx_xfer_end), .clr_udr(stat_clr[2]), .clr_done(stat_clr[1]),
    .popped(tx_popped), .count(tx_cnt), .udr_flag(st_udr),
    .done_flag(st_txdone), .pop_go(pop_go), .udr_evt(udr_evt),
    .zero_evt(zero_evt)
  );

  qpt_rxq u_rxq (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata), .rp_lo_we(rp_lo_we),
    .rp_hi_we(rp_hi_we), .rx_push(rx_push), .cfg_ok(rx_ok), .size(rx_size),
    .linear(linear), .xfer_end(rx_xfer_end), .clr_ovr(stat_clr[3]),
    .clr_done(stat_clr[0]), .wp(rx_wp), .rp(rx_rp), .count(rx_cnt),
    .ovr_flag(st_ovr), .done_flag(st_rxdone), .push_go(push_go),
    .ovr_evt(ovr_evt)
  );

  assign tx_hi = linear ? dtx_hi : base_hi;
  assign tx_lo = linear ? dtx_lo : txb_lo;
  assign rx_hi = linear ? drx_hi : base_hi;
  assign rx_lo = linear ? drx_lo : rxb_lo;

  assign tx_addr = slot_addr(tx_hi, tx_lo, tx_popped, tx_size);
  assign rx_addr = slot_addr(rx_hi, rx_lo, rx_wp, rx_size);

  assign stat_byte = {!tx_ok, !rx_ok, 2'b00, st_ovr, st_udr, st_txdone, st_rxdone};
  assign ctrl_byte = {1'b0, ctl_autoclr, ctl_lin_en, 4'b0000};

  always_comb begin
    case (reg_addr)
      RG_TXB_LO:  reg_rdata = txb_lo;
      RG_RXB_LO:  reg_rdata = rxb_lo;
      RG_BASE_HI: reg_rdata = base_hi;
      RG_SIZE:    reg_rdata = size_codes;
      RG_TXC_LO:  reg_rdata = tx_cnt[7:0];
      RG_TXC_HI:  reg_rdata = tx_cnt[15:8];
      RG_RXC_LO:  reg_rdata = rx_cnt[7:0];
      RG_RXC_HI:  reg_rdata = rx_cnt[15:8];
      RG_RP_LO:   reg_rdata = rx_rp[7:0];
      RG_RP_HI:   reg_rdata = rx_rp[15:8];
      RG_CTRL:    reg_rdata = ctrl_byte;
      RG_STAT:    reg_rdata = stat_byte;
      RG_DTX_LO:  reg_rdata = dtx_lo;
      RG_DTX_HI:  reg_rdata = dtx_hi;
      RG_DRX_LO:  reg_rdata = drx_lo;
      RG_DRX_HI:  reg_rdata = drx_hi;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qpt_tracker_chk.sv
module qpt_tracker_chk
  import qpt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              tx_xfer_end,
  input logic              rx_xfer_end,
  input logic              linear,
  input logic              tx_ok,
  input logic              rx_ok,
  input logic [SZ_W-1:0]   rx_size,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  rx_wp,
  input logic              flush_req,
  input logic              st_udr,
  input logic              st_ovr,
  input logic              st_txdone,
  input logic              st_rxdone
);
  logic [CNT_W-1:0] rx_size_x;
  assign rx_size_x = {{(CNT_W-SZ_W){1'b0}}, rx_size};

  // R4: a pop at zero count is recorded as underrun
  p_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_ok && (tx_cnt == '0) |=> st_udr);

  // R4: a successful pop lowers the count by one
  p_tx_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_ok && (tx_cnt != '0) && !reg_wr && !tx_xfer_end
    |=> tx_cnt == $past(tx_cnt) - 1'b1);

  // R5: flush empties the transmit queue
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> tx_cnt == '0);

  // R6: an accepted push raises the receive count by one
  p_rx_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_ok && (rx_cnt < rx_size_x) && !reg_wr
    |=> rx_cnt == $past(rx_cnt) + 1'b1);

  // R7: a push into a full queue flags overrun and keeps the pointer
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_ok && (rx_cnt == rx_size_x) |=> st_ovr && $stable(rx_wp));

  // R2: an unsupported receive size ignores pushes
  p_cfg_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_ok |=> $stable(rx_wp));

  // R9: done flags only rise after an end strobe in linear mode
  p_txdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st_txdone) && st_txdone |-> $past(tx_xfer_end && linear));
  p_rxdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st_rxdone) && st_rxdone |-> $past(rx_xfer_end && linear));
endmodule

bind qpt_tracker qpt_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .tx_pop(tx_pop),
  .rx_push(rx_push), .tx_xfer_end(tx_xfer_end), .rx_xfer_end(rx_xfer_end),
  .linear(linear), .tx_ok(tx_ok), .rx_ok(rx_ok), .rx_size(rx_size),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_wp(rx_wp), .flush_req(flush_req),
  .st_udr(st_udr), .st_ovr(st_ovr), .st_txdone(st_txdone),
  .st_rxdone(st_rxdone)
);

// File: tb/qpt_tracker_test.sv
module qpt_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic        tx_xfer_end = 1'b0, rx_xfer_end = 1'b0;
  logic [18:0] tx_addr, rx_addr;

  int errs = 0;
  int checks = 0;
  bit reported = 0;

  qpt_tracker uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop),
    .tx_addr(tx_addr), .rx_push(rx_push), .rx_addr(rx_addr),
    .tx_xfer_end(tx_xfer_end), .rx_xfer_end(rx_xfer_end)
  );

  always #5 clk = ~clk;

  function automatic int b_size(input int code);
    if (code == 0) return 16;
    if (code == 5) return 32;
    if (code == 6) return 64;
    if (code == 7) return 128;
    if (code == 12) return 4096;
    return 0;
  endfunction

  function automatic int b_addr(input int hi, input int lo, input int ptr, input int size);
    return ((hi * 2048) + (lo * 8) + (ptr % size)) % (1 << 19);
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = a[4:0]; reg_wdata = d[7:0]; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = a[4:0];
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic pop(output int a);
    @(negedge clk);
    tx_pop = 1'b1;
    #1 a = int'(tx_addr);
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic push(output int a);
    @(negedge clk);
    rx_push = 1'b1;
    #1 a = int'(rx_addr);
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic xend(input bit t, input bit r);
    @(negedge clk);
    tx_xfer_end = t; rx_xfer_end = r;
    @(negedge clk);
    tx_xfer_end = 1'b0; rx_xfer_end = 1'b0;
  endtask

  task automatic cnt16(input int lo_off, output int v);
    int lo, hi;
    rd(lo_off, lo);
    rd(lo_off + 1, hi);
    v = hi * 256 + lo;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int v, a, wp, rp, fill, ovr;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(5'h0D, v); chk("R11 status", v, 0);
    cnt16(5'h06, v); chk("R11 txcnt", v, 0);
    cnt16(5'h08, v); chk("R11 rxcnt", v, 0);
    #1 chk("R11 tx_addr", int'(tx_addr), 0);
    chk("R11 rx_addr", int'(rx_addr), 0);

    // R1 ring bases, shared high byte
    wr(5'h00, 8'h12); wr(5'h01, 8'h34); wr(5'h02, 8'h5A); wr(5'h03, 8'h50);
    #1 chk("R1 tx_addr", int'(tx_addr), b_addr(8'h5A, 8'h12, 0, 16));
    chk("R1 rx_addr", int'(rx_addr), b_addr(8'h5A, 8'h34, 0, 32));

    // R4 length and count, R3 wrap of transmit offset
    wr(5'h04, 20); wr(5'h05, 0);
    cnt16(5'h06, v); chk("R4 txcnt after length", v, 20);
    for (int i = 0; i < 17; i++) begin
      pop(a); chk("R3 tx wrap addr", a, b_addr(8'h5A, 8'h12, i, 16));
    end
    cnt16(5'h06, v); chk("R4 txcnt after pops", v, 3);

    // R5 flush
    wr(5'h0C, 8'h01);
    cnt16(5'h06, v); chk("R5 txcnt after flush", v, 0);
    #1 chk("R5 tx_addr back at base", int'(tx_addr), b_addr(8'h5A, 8'h12, 0, 16));

    // R4 underrun sticky and write-1 clear
    pop(a);
    rd(5'h0D, v); chk("R4 underrun set", v & 4, 4);
    cnt16(5'h06, v); chk("R4 no negative count", v, 0);
    wr(5'h0D, 8'h04);
    rd(5'h0D, v); chk("R4 underrun cleared", v & 4, 0);

    // R6, R7, R3 random receive traffic against a model
    wp = 0; rp = 0; ovr = 0;
    for (int i = 0; i < 300; i++) begin
      int op;
      fill = (wp - rp) & 255;
      op = $urandom % 4;
      if (op < 2) begin
        push(a);
        chk("R3 rx addr", a, b_addr(8'h5A, 8'h34, wp, 32));
        if (fill < 32) wp = (wp + 1) & 16'hFFFF; else ovr = 1;
      end else if (op == 2) begin
        int k;
        k = $urandom % (fill + 1);
        rp = (rp + k) & 255;
        wr(5'h0A, rp);
      end
      cnt16(5'h08, v); chk("R6 rx count", v, (wp - rp) & 255);
      rd(5'h0D, v); chk("R7 overrun sticky", (v >> 3) & 1, ovr);
    end

    // R7 directed overrun at exactly full
    wr(5'h0D, 8'h08);
    while (((wp - rp) & 255) < 32) begin
      push(a); wp = (wp + 1) & 16'hFFFF;
    end
    rd(5'h0D, v); chk("R7 no overrun at fill", v & 8, 0);
    push(a); chk("R7 addr at full", a, b_addr(8'h5A, 8'h34, wp, 32));
    rd(5'h0D, v); chk("R7 overrun on full push", v & 8, 8);
    cnt16(5'h08, v); chk("R7 count held", v, 32);
    #1 chk("R7 pointer held", int'(rx_addr), b_addr(8'h5A, 8'h34, wp, 32));
    wr(5'h0D, 8'h08);

    // R2 unsupported transmit code ignores pops
    wr(5'h04, 5); wr(5'h03, 8'h53);
    rd(5'h0D, v); chk("R2 tx cfg error bit7", v & 8'hC0, 8'h80);
    pop(a);
    cnt16(5'h06, v); chk("R2 pop ignored", v, 5);
    rd(5'h0D, v); chk("R2 no underrun", v & 4, 0);
    wr(5'h03, 8'hC0);
    rd(5'h0D, v); chk("R2 linear code in ring mode", v & 8'hC0, 8'h40);

    // R8 linear mode bases and sizes
    wr(5'h0C, 8'h01);
    wr(5'h03, 8'hCC);
    wr(5'h10, 8'h00); wr(5'h11, 8'h40); wr(5'h12, 8'h08); wr(5'h13, 8'h42);
    wr(5'h0C, 8'h30);
    rd(5'h0D, v); chk("R8 linear codes valid", v & 8'hC0, 0);
    #1 chk("R8 linear tx base", int'(tx_addr), b_addr(8'h40, 8'h00, 0, 4096));
    wr(5'h04, 5);
    pop(a); pop(a);
    #1 chk("R8 linear tx addr", int'(tx_addr), b_addr(8'h40, 8'h00, 2, 4096));
    wr(5'h0A, wp & 255); wr(5'h0B, (wp >> 8) & 255);
    cnt16(5'h08, v); chk("R6 linear rx count zero", v, 0);
    for (int i = 0; i < 3; i++) begin
      push(a);
      chk("R8 linear rx addr", a, b_addr(8'h42, 8'h08, wp, 4096));
      wp = (wp + 1) & 16'hFFFF;
    end
    cnt16(5'h08, v); chk("R6 linear rx count", v, 3);
    wr(5'h0C, 8'h10);
    #1 chk("R8 partial enable uses ring base", int'(rx_addr), b_addr(8'h5A, 8'h34, wp, 4096));
    rd(5'h0D, v); chk("R8 partial enable is ring mode", v & 8'hC0, 8'hC0);

    // R9 done flags
    wr(5'h0C, 8'h30);
    xend(1, 0);
    rd(5'h0D, v); chk("R9 tx done", v & 3, 2);
    xend(0, 1);
    rd(5'h0D, v); chk("R9 rx done", v & 3, 3);
    wr(5'h0D, 8'h02);
    rd(5'h0D, v); chk("R9 tx done cleared", v & 3, 1);
    wr(5'h0D, 8'h01);
    rd(5'h0D, v); chk("R9 rx done cleared", v & 3, 0);
    cnt16(5'h06, v); chk("R10 count kept without auto-clear", v, 3);
    wr(5'h0C, 8'h00);
    xend(1, 1);
    rd(5'h0D, v); chk("R9 ignored in ring mode", v & 3, 0);

    // R10 auto-clear
    wr(5'h0C, 8'h70);
    cnt16(5'h06, v); chk("R10 count before end", v, 3);
    xend(1, 0);
    cnt16(5'h06, v); chk("R10 auto-clear zeroes count", v, 0);
    wr(5'h0D, 8'h03);

    report();
  end
endmodule